// File: doc/BRIEF.md
# Legacy Shadow Region Steering Controller

This block sits in a host bridge and decides, for every memory access into the legacy window between 0xC0000 and 0xFFFFF, whether the access is served by system DRAM or passed on to the firmware/ROM path. Software sets the policy through seven byte-wide attribute registers on a small configuration port. Each region has a two-bit attribute: one bit lets reads reach DRAM and the other lets writes reach DRAM. The two directions are steered independently, so firmware can copy its own image into DRAM and then write-protect it.

Thirteen regions are covered. One is the 64 KB firmware area at 0xF0000. Eight are 16 KB option-ROM slots from 0xC0000 to 0xDFFFF, and four are 16 KB firmware-extension slots from 0xE0000 to 0xEFFFF. The block also places the firmware image in two windows. The first ends at the top of the address space. The second is an alias of the image tail that ends just below 1 MB and is at most 128 KB long. Whenever an access is forwarded inside either window, the block flags it and gives the byte offset into the image. Steering is purely combinational from the current register contents.

Top module: `shd_attr_ctrl`

## Requirements
- R1: After reset, the seven attribute registers at configuration addresses 0x59..0x5F all read 0x00. Any other configuration address reads 0x00.
- R2: A configuration write with `cfg_we` high to an address in 0x59..0x5F stores all 8 data bits as given, and they read back unchanged. Writes to other addresses change nothing.
- R3: Region index i uses register 0x59 + i/2: bits [3:0] when i is even, bits [7:4] when i is odd. Index 1 is 0xF0000..0xFFFFF. Indices 2..9 are 16 KB slots rising from 0xC0000. Indices 10..13 are 16 KB slots rising from 0xE0000.
- R4: A read inside a region goes to DRAM (`sel_dram`=1) when nibble bit 0 is set. Otherwise it is forwarded (`sel_fwd`=1).
- R5: A write inside a region goes to DRAM when nibble bit 1 is set. Otherwise it is forwarded and `sel_dram` stays 0. When `mem_rd` and `mem_wr` are both high, the access is treated as a write.
- R6: Accesses below 0xC0000, or at 0x100000 and above but below the high firmware window, always select DRAM.
- R7: Accesses in the high firmware window (the top FW_BYTES of the address space) are always forwarded with `fw_hit`=1 and `fw_offset` = address − window base.
- R8: A forwarded access in the low alias window (the top min(FW_BYTES,128 KB) below 0x100000) gives `fw_hit`=1 and `fw_offset` = FW_BYTES − alias size + (address − alias base). A forwarded access anywhere else gives `fw_hit`=0.
- R9: With no request, `sel_dram`, `sel_fwd` and `fw_hit` are all 0. With a request, exactly one of `sel_dram` and `sel_fwd` is 1.
- R10: An attribute written at a clock edge governs accesses presented in the cycle after that edge. Before that edge, the old value still applies.
- R11: The nibble for index 0 (bits [3:0] of 0x59) is stored but steers no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write enable |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| mem_addr | input | ADDR_W | Memory access address |
| mem_rd | input | 1 | Read request strobe |
| mem_wr | input | 1 | Write request strobe |
| sel_dram | output | 1 | Access goes to system DRAM |
| sel_fwd | output | 1 | Access is forwarded to the ROM/bus path |
| fw_hit | output | 1 | Forwarded access falls in a firmware image window |
| fw_offset | output | log2(FW_BYTES) | Byte offset into the firmware image |

## Verification
The bench steps every attribute value through each of the thirteen regions. After each write it probes the first and last byte of every region for both reads and writes. This catches a nibble taken from the wrong half or the wrong register, a read and write bit swapped, and a slot boundary off by one; each of those would steer a neighbouring region, or the opposite direction, the wrong way. The index-0 nibble is set to show that a decoder folding it onto the firmware area would wrongly open that area to DRAM. Probes also cover the edges of the high window and the alias window, where a wrong base or size would misreport `fw_hit` or the offset. The one-cycle timing of a new attribute is checked on both sides of the write edge.

// File: rtl/shd_pkg.sv
package shd_pkg;

    localparam int NUM_REGS  = 7;
    localparam int IDX_W     = 4;
    localparam int REG_SEL_W = 3;

    // bit 1 = write enable, bit 0 = read enable
    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } attr_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } region_t;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_DRAM = 2'd1,
        ROUTE_FWD  = 2'd2
    } route_e;

    // a1914 holds address bits [19:14] of an address below 1 MB
    function automatic region_t decode_region(logic [5:0] a1914);
        region_t r;
        r = '0;
        if (a1914[5:4] == 2'b11) begin
            r.hit = 1'b1;
            if (!a1914[3])
                r.idx = 4'd2 + {1'b0, a1914[2:0]};
            else if (!a1914[2])
                r.idx = 4'd10 + {2'b00, a1914[1:0]};
            else
                r.idx = 4'd1;
        end
        return r;
    endfunction

    function automatic attr_t pick_nibble(logic [7:0] byte_val, logic odd);
        logic [3:0] nib;
        nib = odd ? byte_val[7:4] : byte_val[3:0];
        return attr_t'(nib[1:0]);
    endfunction

endpackage

// File: rtl/shd_attr_regs.sv
module shd_attr_regs #(
    parameter int          NUM_REGS = 7,
    parameter logic [7:0]  CFG_BASE = 8'h59
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    input  logic                  cfg_we,
    output logic [7:0]            cfg_rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_flat[g*8 +: 8] <= 8'h00;
            else if (cfg_we && (cfg_addr == CFG_BASE + 8'(g)))
                regs_flat[g*8 +: 8] <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (cfg_addr == CFG_BASE + 8'(k))
                cfg_rdata = regs_flat[k*8 +: 8];
        end
    end

endmodule

// File: rtl/shd_region_decode.sv
module shd_region_decode
    import shd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);

    logic below_1m;

    assign below_1m = ~|addr[ADDR_W-1:20];

    always_comb begin
        region = '0;
        if (below_1m)
            region = decode_region(addr[19:14]);
    end

endmodule

// File: rtl/shd_fw_alias.sv
module shd_fw_alias #(
    parameter int ADDR_W    = 32,
    parameter int FW_BYTES  = 65536,
    parameter int ALIAS_MAX = 131072,
    localparam int OFF_W    = $clog2(FW_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hi_hit,
    output logic              lo_hit,
    output logic [OFF_W-1:0]  offset
);

    localparam int ALIAS_BYTES = (FW_BYTES < ALIAS_MAX) ? FW_BYTES : ALIAS_MAX;
    localparam logic [ADDR_W-1:0] HI_BASE  = ~ADDR_W'(FW_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE_MB   = ADDR_W'(32'h0010_0000);
    localparam logic [ADDR_W-1:0] LO_BASE  = ONE_MB - ADDR_W'(ALIAS_BYTES);

    assign hi_hit = (addr >= HI_BASE);
    assign lo_hit = (addr >= LO_BASE) && (addr < ONE_MB);

    // Both windows end on a FW_BYTES-aligned boundary, so the image offset
    // is the address modulo the image size in either window.
    assign offset = addr[OFF_W-1:0];

endmodule

// File: rtl/shd_route.sv
module shd_route
    import shd_pkg::*;
(
    input  logic   mem_rd,
    input  logic   mem_wr,
    input  logic   in_region,
    input  attr_t  attr,
    input  logic   hi_hit,
    input  logic   lo_hit,
    output route_e route,
    output logic   fw_window
);

    logic req;
    logic enable;

    assign req    = mem_rd | mem_wr;
    assign enable = mem_wr ? attr.wr_en : attr.rd_en;

    always_comb begin
        if (!req)
            route = ROUTE_NONE;
        else if (hi_hit)
            route = ROUTE_FWD;
        else if (!in_region)
            route = ROUTE_DRAM;
        else if (enable)
            route = ROUTE_DRAM;
        else
            route = ROUTE_FWD;
    end

    assign fw_window = (route == ROUTE_FWD) && (hi_hit || lo_hit);

endmodule

// File: rtl/shd_attr_ctrl.sv
module shd_attr_ctrl
    import shd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FW_BYTES  = 65536,
    parameter int ALIAS_MAX = 131072,
    localparam int OFF_W    = $clog2(FW_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic              sel_dram,
    output logic              sel_fwd,
    output logic              fw_hit,
    output logic [OFF_W-1:0]  fw_offset
);

    logic [NUM_REGS*8-1:0] regs_flat;
    region_t               region;
    logic [REG_SEL_W-1:0]  reg_sel;
    logic [7:0]            reg_byte;
    attr_t                 attr;
    logic                  hi_hit;
    logic                  lo_hit;
    logic [OFF_W-1:0]      offset;
    route_e                route;
    logic                  fw_window;

    shd_attr_regs #(
        .NUM_REGS (NUM_REGS),
        .CFG_BASE (8'h59)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_we    (cfg_we),
        .cfg_rdata (cfg_rdata),
        .regs_flat (regs_flat)
    );

    shd_region_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr   (mem_addr),
        .region (region)
    );

    assign reg_sel  = region.idx[IDX_W-1:1];
    assign reg_byte = regs_flat[reg_sel*8 +: 8];
    assign attr     = pick_nibble(reg_byte, region.idx[0]);

    shd_fw_alias #(
        .ADDR_W    (ADDR_W),
        .FW_BYTES  (FW_BYTES),
        .ALIAS_MAX (ALIAS_MAX)
    ) u_alias (
        .addr   (mem_addr),
        .hi_hit (hi_hit),
        .lo_hit (lo_hit),
        .offset (offset)
    );

    shd_route u_route (
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .in_region (region.hit),
        .attr      (attr),
        .hi_hit    (hi_hit),
        .lo_hit    (lo_hit),
        .route     (route),
        .fw_window (fw_window)
    );

    assign sel_dram  = (route == ROUTE_DRAM);
    assign sel_fwd   = (route == ROUTE_FWD);
    assign fw_hit    = fw_window;
    assign fw_offset = fw_window ? offset : '0;

endmodule

// File: rtl/shd_attr_checker.sv
module shd_attr_checker #(
    parameter int ADDR_W   = 32,
    parameter int FW_BYTES = 65536,
    localparam int OFF_W   = $clog2(FW_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              sel_dram,
    input logic              sel_fwd,
    input logic              fw_hit,
    input logic [OFF_W-1:0]  fw_offset
);

    localparam logic [ADDR_W-1:0] HI_BASE = ~ADDR_W'(FW_BYTES - 1);

    logic req;
    logic in_fw_area;
    assign req        = mem_rd | mem_wr;
    assign in_fw_area = (mem_addr >= ADDR_W'(32'h000F_0000)) &&
                        (mem_addr <  ADDR_W'(32'h0010_0000));

    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_dram, sel_fwd}));                                    // R9
    AST_REQ_ROUTED: assert property (@(posedge clk) disable iff (rst)
        req |-> (sel_dram || sel_fwd));                                    // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req |-> (!sel_dram && !sel_fwd && !fw_hit));                      // R9
    AST_HIGH_FWD: assert property (@(posedge clk) disable iff (rst)
        (req && mem_addr >= HI_BASE) |->
            (sel_fwd && fw_hit && fw_offset == OFF_W'(mem_addr - HI_BASE))); // R7
    AST_LOW_DRAM: assert property (@(posedge clk) disable iff (rst)
        (req && mem_addr < ADDR_W'(32'h000C_0000)) |-> sel_dram);          // R6
    AST_HIT_FWD: assert property (@(posedge clk) disable iff (rst)
        fw_hit |-> sel_fwd);                                               // R8
    AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_we && cfg_addr == 8'h59) && mem_rd && !mem_wr && in_fw_area)
            |-> (sel_dram == $past(cfg_wdata[4])));                        // R10

endmodule

bind shd_attr_ctrl shd_attr_checker #(
    .ADDR_W   (ADDR_W),
    .FW_BYTES (FW_BYTES)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .sel_dram  (sel_dram),
    .sel_fwd   (sel_fwd),
    .fw_hit    (fw_hit),
    .fw_offset (fw_offset)
);

// File: tb/shd_attr_ctrl_bench.sv
`timescale 1ns/1ps
module shd_attr_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
    logic        cfg_we;
    logic [31:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic        sel_dram, sel_fwd, fw_hit;
    logic [15:0] fw_offset;

    int checks = 0;
    int errors = 0;
    logic [7:0] m [0:6];

    always #10 clk = ~clk;

    shd_attr_ctrl u_shd_attr_ctrl (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .sel_dram(sel_dram),
        .sel_fwd(sel_fwd), .fw_hit(fw_hit), .fw_offset(fw_offset)
    );

    function automatic int region_of(logic [31:0] a);
        if (a >= 32'hC0000 && a < 32'hE0000) return 2 + int'((a - 32'hC0000) / 16384);
        if (a >= 32'hE0000 && a < 32'hF0000) return 10 + int'((a - 32'hE0000) / 16384);
        if (a >= 32'hF0000 && a < 32'h100000) return 1;
        return -1;
    endfunction

    // {dram, fwd, hit, offset}
    function automatic logic [18:0] expect_route(logic [31:0] a, bit wr);
        int idx;
        logic [7:0] b;
        logic [1:0] nib;
        bit en, hit;
        if (a >= 32'hFFFF0000) return {1'b0, 1'b1, 1'b1, 16'(a - 32'hFFFF0000)};
        idx = region_of(a);
        if (idx < 0) return {1'b1, 1'b0, 1'b0, 16'h0};
        b   = m[idx / 2];
        nib = (idx % 2 == 1) ? b[5:4] : b[1:0];
        en  = wr ? nib[1] : nib[0];
        if (en) return {1'b1, 1'b0, 1'b0, 16'h0};
        hit = (a >= 32'hF0000);
        return {1'b0, 1'b1, hit, hit ? 16'(a - 32'hF0000) : 16'h0};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // called just after a falling edge; combinational probe
    task automatic probe(string req, logic [31:0] a, bit wr, bit both);
        logic [18:0] exp;
        mem_addr = a;
        mem_wr   = wr;
        mem_rd   = !wr || both;
        #2;
        exp = expect_route(a, wr);
        check(req, {13'h0, sel_dram, sel_fwd, fw_hit, fw_offset}, {13'h0, exp},
              $sformatf("addr %h wr %0d", a, wr));
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        #1;
    endtask

    task automatic cfg_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h59 && a <= 8'h5F) m[a - 8'h59] = d;
    endtask

    task automatic check_regs(string req);
        for (int r = 8'h58; r <= 8'h60; r++) begin
            cfg_addr = 8'(r);
            #1;
            check(req, {24'h0, cfg_rdata},
                  {24'h0, (r >= 8'h59 && r <= 8'h5F) ? m[r - 8'h59] : 8'h00},
                  $sformatf("readback %h", r));
        end
    endtask

    task automatic sweep_all(string req);
        logic [31:0] base;
        for (int i = 1; i < 14; i++) begin
            if (i == 1) base = 32'hF0000;
            else if (i < 10) base = 32'hC0000 + 32'((i - 2) * 16384);
            else base = 32'hE0000 + 32'((i - 10) * 16384);
            probe(req, base, 1'b0, 1'b0);
            probe(req, base, 1'b1, 1'b0);
            probe(req, base + ((i == 1) ? 32'hFFFF : 32'h3FFF), 1'b0, 1'b0);
            probe(req, base + ((i == 1) ? 32'hFFFF : 32'h3FFF), 1'b1, 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
        mem_addr = 32'h0; mem_rd = 1'b0; mem_wr = 1'b0;
        for (int r = 0; r < 7; r++) m[r] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values and unmapped reads
        check_regs("R1");
        // R9: idle means no select
        mem_addr = 32'hF0000; #1;
        check("R9", {29'h0, sel_dram, sel_fwd, fw_hit}, 32'h0, "idle selects");
        // R6 / R7 / R8 with all attributes clear
        probe("R6", 32'h00000000, 1'b0, 1'b0);
        probe("R6", 32'h000BFFFF, 1'b1, 1'b0);
        probe("R6", 32'h00100000, 1'b1, 1'b0);
        probe("R6", 32'h12345678, 1'b0, 1'b0);
        probe("R6", 32'hFFFEFFFF, 1'b0, 1'b0);
        probe("R7", 32'hFFFF0000, 1'b0, 1'b0);
        probe("R7", 32'hFFFF8001, 1'b1, 1'b0);
        probe("R7", 32'hFFFFFFFF, 1'b0, 1'b0);
        probe("R8", 32'h000F0000, 1'b0, 1'b0);
        probe("R8", 32'h000FFFFF, 1'b0, 1'b0);
        probe("R8", 32'h000EFFFF, 1'b0, 1'b0);

        // R2: full-byte write and readback, outside writes ignored
        cfg_write(8'h5C, 8'hA5);
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        check_regs("R2");
        cfg_write(8'h5C, 8'h00);

        // R11: index-0 nibble steers nothing
        cfg_write(8'h59, 8'h03);
        sweep_all("R11");
        probe("R11", 32'h00000000, 1'b1, 1'b0);
        cfg_write(8'h59, 8'h00);

        // R3 / R4 / R5: every attribute value in every region, all regions probed
        for (int i = 1; i < 14; i++) begin
            for (int v = 0; v < 4; v++) begin
                logic [7:0] nb;
                nb = m[i / 2];
                if (i % 2 == 1) nb = {4'(v), nb[3:0]};
                else nb = {nb[7:4], 4'(v)};
                cfg_write(8'h59 + 8'(i / 2), nb);
                sweep_all((v[0]) ? "R4" : ((v[1]) ? "R5" : "R3"));
            end
        end
        // R5: simultaneous read and write follows the write bit
        cfg_write(8'h5A, 8'h01);   // index 2 (0xC0000) read-only to DRAM
        probe("R5", 32'h000C0000, 1'b1, 1'b1);
        probe("R4", 32'h000C2000, 1'b0, 1'b0);
        cfg_write(8'h5A, 8'h02);
        probe("R5", 32'h000C2000, 1'b1, 1'b1);
        // R8: alias reports no hit once reads reach DRAM
        cfg_write(8'h59, 8'h10);
        probe("R8", 32'h000F1234, 1'b0, 1'b0);
        probe("R8", 32'h000F1234, 1'b1, 1'b0);

        // R10: new attribute applies after the write edge, not before
        cfg_write(8'h59, 8'h00);
        cfg_addr = 8'h59; cfg_wdata = 8'h10; cfg_we = 1'b1;
        mem_addr = 32'hF8000; mem_rd = 1'b1;
        #2;
        check("R10", {30'h0, sel_dram, sel_fwd}, 32'h1, "before edge");
        @(posedge clk); #2;
        cfg_we = 1'b0; m[0] = 8'h10;
        check("R10", {30'h0, sel_dram, sel_fwd}, 32'h2, "after edge");
        @(negedge clk);
        mem_rd = 1'b0;

        // R1: reset clears programmed registers
        cfg_write(8'h5F, 8'h33);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 7; r++) m[r] = 8'h00;
        check_regs("R1");
        probe("R1", 32'h000EC000, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule